// File: doc/BRIEF.md
# Effective Address Generator

This unit turns a decoded 16-bit instruction word into the memory address the instruction refers to. It combines three address sources: the incremented program counter, a base register value, and a pointer word read from memory. A start pulse presents the instruction word, the incremented PC and the value of the base register that the instruction names. One cycle later the unit gives the address. With it come a flag that says whether memory must be accessed at that address, and a done strobe.

For the indirect forms the unit runs two phases. First it issues the address of the pointer location with the access flag raised, and it raises busy. It then waits for the memory system to return the pointer word with a valid pulse. That word becomes the final address, issued with the access flag and done. Register file reads, memory timing and writeback belong to the surrounding datapath.

Top module: `eff_addr_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after it, addr is 0 and mem_req, done and busy are 0.
- R2: A start with opcode ir[15:12] = 4'b0010 or 4'b0011 gives, in the next cycle, addr = pc_inc + sign-extended ir[8:0], with mem_req = 1, done = 1 and busy = 0.
- R3: A start with opcode 4'b1110 or 4'b0000 gives the same PC-relative address as R2 in the next cycle, with done = 1 and mem_req = 0.
- R4: A start with opcode 4'b0110 or 4'b0111 gives, in the next cycle, addr = base_val + sign-extended ir[5:0], with mem_req = 1 and done = 1.
- R5: A start with opcode 4'b1100 gives, in the next cycle, addr = base_val unchanged, with mem_req = 0 and done = 1.
- R6: A start with opcode 4'b1010 or 4'b1011 gives, in the next cycle, the PC-relative pointer address of R2 on addr, with mem_req = 1, done = 0 and busy = 1.
- R7: While busy, a mem_valid pulse gives, in the next cycle, addr = mem_data, mem_req = 1, done = 1 and busy = 0. Until that pulse, done and mem_req stay 0, addr holds the pointer address and busy stays 1.
- R8: A start while busy is ignored, also when it comes in the same cycle as mem_valid. A mem_valid while not busy is ignored: addr holds, and mem_req and done stay 0.
- R9: A start with any other opcode gives addr = 0, mem_req = 0 and done = 1 in the next cycle.
- R10: All address sums wrap modulo 2^16. Sign extension copies the top bit of the field into every upper bit.
- R11: done and mem_req are one-cycle strobes. In a cycle after which neither a start was accepted nor a pointer arrived, both are 0, and addr keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for ir |
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter already incremented |
| base_val | input | 16 | Value of the base register named by ir[8:6] |
| mem_data | input | 16 | Pointer word returned by memory |
| mem_valid | input | 1 | One-cycle pulse: mem_data is valid |
| addr | output | 16 | Generated address |
| mem_req | output | 1 | Memory access needed at addr (strobe) |
| done | output | 1 | Final address is on addr (strobe) |
| busy | output | 1 | Waiting for a pointer word |

## Verification
Two events can fall in the same cycle: the pointer word arriving for a pending indirect access, and a new start request. The bench sweeps every opcode with all 512 values of the low offset field. During each indirect wait it keeps start raised. On alternate cases it raises start in the same cycle as mem_valid. In those cases the result must carry the returned pointer word and must clear busy, and the unit must show no trace of the competing instruction. The bench also pulses mem_valid while the unit is idle and checks that addr and the strobes do not move.

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  ir,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] mem_data,
  input  logic         mem_valid,
  output logic [W-1:0] addr,
  output logic         mem_req,
  output logic         done,
  output logic         busy
);

  localparam logic [3:0] OP_BR  = 4'b0000;
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_JMP = 4'b1100;
  localparam logic [3:0] OP_LEA = 4'b1110;

  logic [3:0]   op;
  logic [W-1:0] off9, off6, pc_ea, base_ea;
  logic [W-1:0] nxt_addr;
  logic         nxt_req, nxt_ind;
  logic         waiting;

  assign op      = ir[15:12];
  assign off9    = {{(W-9){ir[8]}}, ir[8:0]};
  assign off6    = {{(W-6){ir[5]}}, ir[5:0]};
  assign pc_ea   = pc_inc + off9;
  assign base_ea = base_val + off6;
  assign busy    = waiting;

  always_comb begin
    nxt_addr = '0;
    nxt_req  = 1'b0;
    nxt_ind  = 1'b0;
    case (op)
      OP_LD, OP_ST:   begin nxt_addr = pc_ea;    nxt_req = 1'b1; end
      OP_BR, OP_LEA:  begin nxt_addr = pc_ea;                    end
      OP_LDR, OP_STR: begin nxt_addr = base_ea;  nxt_req = 1'b1; end
      OP_JMP:         begin nxt_addr = base_val;                 end
      OP_LDI, OP_STI: begin nxt_addr = pc_ea;    nxt_req = 1'b1; nxt_ind = 1'b1; end
      default:        ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      mem_req <= 1'b0;
      done    <= 1'b0;
      waiting <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      if (waiting) begin
        if (mem_valid) begin
          addr    <= mem_data;
          mem_req <= 1'b1;
          done    <= 1'b1;
          waiting <= 1'b0;
        end
      end else if (start) begin
        addr    <= nxt_addr;
        mem_req <= nxt_req;
        done    <= !nxt_ind;
        waiting <= nxt_ind;
      end
    end
  end

endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [15:0]  ir,
  input logic [W-1:0] base_val,
  input logic [W-1:0] mem_data,
  input logic         mem_valid,
  input logic [W-1:0] addr,
  input logic         mem_req,
  input logic         done,
  input logic         busy
);

  // R5
  jump_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ir[15:12] == 4'b1100) |=> (addr == $past(base_val) && !mem_req && done));

  // R6
  indirect_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ir[15:13] == 3'b101) |=> (busy && mem_req && !done));

  // R7
  pointer_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid) |=> (!busy && done && mem_req && addr == $past(mem_data)));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |=> (busy && $stable(addr) && !done && !mem_req));

  // R11
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!done && !mem_req && $stable(addr)));

endmodule

bind eff_addr_unit eff_addr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ir(ir), .base_val(base_val),
  .mem_data(mem_data), .mem_valid(mem_valid), .addr(addr),
  .mem_req(mem_req), .done(done), .busy(busy)
);

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ir = '0, pc_inc = '0, base_val = '0, mem_data = '0;
  logic        mem_valid = 1'b0;
  logic [15:0] addr;
  logic        mem_req, done, busy;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .ir(ir), .pc_inc(pc_inc),
    .base_val(base_val), .mem_data(mem_data), .mem_valid(mem_valid),
    .addr(addr), .mem_req(mem_req), .done(done), .busy(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, int a, int r, int d, int b);
    chk(req, "addr", int'(addr), a);
    chk(req, "mem_req", int'(mem_req), r);
    chk(req, "done", int'(done), d);
    chk(req, "busy", int'(busy), b);
  endtask

  function automatic int sx(int v, int bits);
    int half = 1 << (bits - 1);
    return (v >= half) ? v - (1 << bits) : v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    // R1
    chk_out("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1", 0, 0, 0, 0);
    last = 0;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 512; k++) begin
        int pc, bs, sum, e_addr, e_req, raw;
        bit ind;
        string tag;
        pc = (16'hFF00 + k * 37 + op * 911) & 16'hFFFF;
        bs = (k * 129 + op * 4099 + 16'hFFE0) & 16'hFFFF;
        ir = 16'((op << 12) | (((k * 5) & 7) << 9) | k);
        pc_inc = 16'(pc);
        base_val = 16'(bs);
        ind = 0; e_req = 0; raw = 0; tag = "R9";
        case (op)
          2, 3:   begin raw = pc + sx(k, 9); e_req = 1; tag = "R2"; end
          0, 14:  begin raw = pc + sx(k, 9); tag = "R3"; end
          6, 7:   begin raw = bs + sx(k & 63, 6); e_req = 1; tag = "R4"; end
          12:     begin raw = bs; tag = "R5"; end
          10, 11: begin raw = pc + sx(k, 9); e_req = 1; ind = 1; tag = "R6"; end
          default: raw = 0;
        endcase
        if (raw > 16'hFFFF || raw < 0) tag = "R10";
        sum = raw & 16'hFFFF;
        e_addr = sum;
        start = 1'b1;
        mem_valid = (k % 8 == 5);
        mem_data = 16'hDEAD;
        @(negedge clk);
        start = 1'b0;
        mem_valid = 1'b0;
        if (!ind) begin
          chk_out(tag, e_addr, e_req, 1, 0);
        end else begin
          chk_out(tag, e_addr, 1, 0, 1);
          for (int w = 0; w < k % 3; w++) begin
            start = 1'b1;
            ir = 16'h2000 | 16'(k);
            @(negedge clk);
            start = 1'b0;
            // R7 R8
            chk_out("R8", e_addr, 0, 0, 1);
          end
          mem_data = 16'((k * 123) ^ 16'hA5A5);
          mem_valid = 1'b1;
          start = k[0];
          ir = 16'h6000;
          @(negedge clk);
          mem_valid = 1'b0;
          start = 1'b0;
          chk_out(k[0] ? "R8" : "R7", (k * 123) ^ 16'hA5A5, 1, 1, 0);
          e_addr = (k * 123) ^ 16'hA5A5;
        end
        mem_valid = (k % 4 == 0);
        mem_data = 16'h1234;
        @(negedge clk);
        mem_valid = 1'b0;
        // R11
        chk_out(mem_valid ? "R8" : "R11", e_addr, 0, 0, 0);
        last = e_addr;
      end
    end
    // R1: reset mid-wait
    ir = 16'hA001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule